// File: doc/BRIEF.md
# Per-CPU Interrupt Priority Presenter

This block sits next to one processor and decides whether that processor should be interrupted. Interrupt sources deliver notification events, each tagged with a priority where a smaller number is more urgent. The block keeps every priority that is waiting in an 8-bit pending mask. From that mask it derives the most urgent waiting priority. It then compares that priority against a threshold that software writes for the processor.

When a waiting priority is more urgent than the threshold, an exception flag is set in a status byte and the interrupt line is raised. Software takes the interrupt by pulsing the acknowledge strobe. The strobe retires the most urgent waiting priority, moves the threshold to that level and lowers the line. After that, only strictly more urgent work can interrupt the processor again. All four state bytes can be read at the ports at all times.

Top module: `ipp_presenter`

## Requirements
- R1: A notification with priority p in 0..7 sets bit (7 - p) of `pend_buf`, so priority 0 is bit 7. New bits are ORed in, so several levels can be pending at once.
- R2: A notification whose priority lies in 8..254 leaves `pend_buf` unchanged.
- R3: A notification with priority 0xFF is discarded. `pend_buf`, `pend_prio`, `cur_prio` and `irq` all keep their values.
- R4: `pend_prio` equals the number of leading zeros of `pend_buf`, counted from bit 7, and it reads 0xFF when `pend_buf` is zero.
- R5: A threshold write of 0..7 stores that value in `cur_prio`. A write above 7 stores 0xFF, which lets every pending level through.
- R6: Whenever `pend_prio` is numerically less than `cur_prio`, the exception flag is set on the next clock edge. The flag appears on `irq` and as bit 7 of `status`, and the other status bits are always 0. The flag stays set until an acknowledge clears it.
- R7: An acknowledge does three things at once. It clears the `pend_buf` bit of the current `pend_prio`, it loads `cur_prio` with that `pend_prio` value, and it clears the exception flag. When nothing is pending, an acknowledge leaves the mask empty and loads 0xFF into `cur_prio`.
- R8: When an acknowledge and a threshold write arrive in the same cycle, the acknowledge decides `cur_prio`. When an acknowledge and a notification arrive in the same cycle, the notification's bit is set after the acknowledged bit is cleared.
- R9: `pend_buf` and `pend_prio` show the effect of an event right after the clock edge that takes it. `irq` responds one clock edge later.
- R10: A synchronous active-high reset clears `pend_buf`, `status` and `cur_prio` and deasserts `irq`. After reset `pend_prio` reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ntf_valid | input | 1 | Notification event strobe |
| ntf_prio | input | 8 | Priority carried by the notification |
| cur_wr_en | input | 1 | Threshold write strobe |
| cur_wr_data | input | 8 | Threshold write value |
| ack_strobe | input | 1 | Acknowledge of the most urgent pending level |
| pend_buf | output | 8 | Pending mask (bit 7 is priority 0) |
| pend_prio | output | 8 | Most urgent pending priority, 0xFF if none |
| cur_prio | output | 8 | Current processor priority threshold |
| status | output | 8 | Status byte; bit 7 is the exception flag |
| irq | output | 1 | Interrupt line to the processor |

## Verification
An event applied before a clock edge shows up in `pend_buf`, `pend_prio` and `cur_prio` right after that edge. `irq` and the status flag settle only after the following edge. The table-driven steps therefore add one idle cycle after each event and only then compare all outputs. A separate directed step samples straight after the first edge and again after the second, to prove the one-cycle lag of `irq`. Same-cycle collisions, an acknowledge with nothing pending, the dropped 0xFF code and a reset in the middle of a run are driven as directed cases.

// File: rtl/ipp_pkg.sv
package ipp_pkg;
  localparam int NUM_LVL   = 8;
  localparam int PRIO_W    = 8;
  localparam int LVL_W     = $clog2(NUM_LVL);
  localparam logic [PRIO_W-1:0] PRIO_NONE = '1;
  localparam int EXC_BIT   = 7;

  // One-hot pending mask for a priority; levels outside the range give no bit.
  function automatic logic [NUM_LVL-1:0] prio_to_mask(input logic [PRIO_W-1:0] p);
    logic [NUM_LVL-1:0] top;
    top = {1'b1, {(NUM_LVL-1){1'b0}}};
    if (p >= PRIO_W'(NUM_LVL)) return '0;
    return top >> p[LVL_W-1:0];
  endfunction

  // Threshold values beyond the last level collapse to "allow all".
  function automatic logic [PRIO_W-1:0] clamp_cur(input logic [PRIO_W-1:0] d);
    if (d >= PRIO_W'(NUM_LVL)) return PRIO_NONE;
    return d;
  endfunction
endpackage

// File: rtl/ipp_pend_buf.sv
module ipp_pend_buf #(
  parameter int NUM_LVL = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_LVL-1:0] set_mask,
  input  logic [NUM_LVL-1:0] clr_mask,
  output logic [NUM_LVL-1:0] buf_q
);
  // Clear first, then set: a new arrival wins over a retirement.
  always_ff @(posedge clk) begin
    if (rst) buf_q <= '0;
    else     buf_q <= (buf_q & ~clr_mask) | set_mask;
  end
endmodule

// File: rtl/ipp_prio_enc.sv
module ipp_prio_enc #(
  parameter int NUM_LVL = 8,
  parameter int PRIO_W  = 8
) (
  input  logic [NUM_LVL-1:0] mask,
  output logic [PRIO_W-1:0]  prio
);
  logic [NUM_LVL:0]   seen;   // seen[i]: some bit among the i topmost is set
  logic [NUM_LVL-1:0] hit;    // hit[i]: level i is the most urgent one
  logic [PRIO_W-1:0]  term [NUM_LVL];

  assign seen[0] = 1'b0;
  for (genvar i = 0; i < NUM_LVL; i++) begin : g_lvl
    assign hit[i]    = mask[NUM_LVL-1-i] & ~seen[i];
    assign seen[i+1] = seen[i] | mask[NUM_LVL-1-i];
    assign term[i]   = hit[i] ? PRIO_W'(i) : '0;
  end

  always_comb begin
    prio = '0;
    for (int i = 0; i < NUM_LVL; i++) prio = prio | term[i];
    if (!seen[NUM_LVL]) prio = '1;
  end
endmodule

// File: rtl/ipp_cur_reg.sv
module ipp_cur_reg #(
  parameter int PRIO_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [PRIO_W-1:0] wr_val,
  input  logic              ack_fire,
  input  logic [PRIO_W-1:0] ack_val,
  output logic [PRIO_W-1:0] cur_q
);
  always_ff @(posedge clk) begin
    if (rst)           cur_q <= '0;
    else if (ack_fire) cur_q <= ack_val;
    else if (wr_en)    cur_q <= wr_val;
  end
endmodule

// File: rtl/ipp_exc_gate.sv
module ipp_exc_gate #(
  parameter int PRIO_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PRIO_W-1:0] pend_prio,
  input  logic [PRIO_W-1:0] cur_prio,
  input  logic              ack_fire,
  output logic              favored,
  output logic              exc_q
);
  assign favored = pend_prio < cur_prio;

  always_ff @(posedge clk) begin
    if (rst)           exc_q <= 1'b0;
    else if (ack_fire) exc_q <= 1'b0;
    else if (favored)  exc_q <= 1'b1;
  end
endmodule

// File: rtl/ipp_presenter.sv
module ipp_presenter
  import ipp_pkg::*;
#(
  parameter int LVLS = NUM_LVL,
  parameter int PW   = PRIO_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ntf_valid,
  input  logic [PW-1:0] ntf_prio,
  input  logic          cur_wr_en,
  input  logic [PW-1:0] cur_wr_data,
  input  logic          ack_strobe,
  output logic [LVLS-1:0] pend_buf,
  output logic [PW-1:0] pend_prio,
  output logic [PW-1:0] cur_prio,
  output logic [PW-1:0] status,
  output logic          irq
);
  // Named internal events for the checker
  logic              ntf_accept;
  logic              ack_fire;
  logic              favored;
  logic              exc_q;
  logic [LVLS-1:0]   ntf_mask;
  logic [LVLS-1:0]   ack_mask;
  logic [PW-1:0]     cur_wr_val;

  assign ntf_accept = ntf_valid && (ntf_prio != PRIO_NONE);
  assign ack_fire   = ack_strobe;
  assign ntf_mask   = ntf_accept ? prio_to_mask(ntf_prio) : '0;
  assign ack_mask   = ack_fire ? prio_to_mask(pend_prio) : '0;
  assign cur_wr_val = clamp_cur(cur_wr_data);

  ipp_pend_buf #(.NUM_LVL(LVLS)) u_buf (
    .clk(clk), .rst(rst), .set_mask(ntf_mask), .clr_mask(ack_mask), .buf_q(pend_buf)
  );

  ipp_prio_enc #(.NUM_LVL(LVLS), .PRIO_W(PW)) u_enc (
    .mask(pend_buf), .prio(pend_prio)
  );

  ipp_cur_reg #(.PRIO_W(PW)) u_cur (
    .clk(clk), .rst(rst), .wr_en(cur_wr_en), .wr_val(cur_wr_val),
    .ack_fire(ack_fire), .ack_val(pend_prio), .cur_q(cur_prio)
  );

  ipp_exc_gate #(.PRIO_W(PW)) u_gate (
    .clk(clk), .rst(rst), .pend_prio(pend_prio), .cur_prio(cur_prio),
    .ack_fire(ack_fire), .favored(favored), .exc_q(exc_q)
  );

  always_comb begin
    status          = '0;
    status[EXC_BIT] = exc_q;
  end
  assign irq = exc_q;
endmodule

// File: rtl/ipp_presenter_chk.sv
module ipp_presenter_chk (
  input logic       clk,
  input logic       rst,
  input logic       ntf_valid,
  input logic [7:0] ntf_prio,
  input logic       cur_wr_en,
  input logic [7:0] cur_wr_data,
  input logic       ack_strobe,
  input logic [7:0] pend_buf,
  input logic [7:0] pend_prio,
  input logic [7:0] cur_prio,
  input logic [7:0] status,
  input logic       irq
);
  AST_NTF_SETS_BIT: assert property (@(posedge clk) disable iff (rst)
    (ntf_valid && ntf_prio < 8'd8) |=> ((pend_buf & (8'h80 >> $past(ntf_prio[2:0]))) != 8'h00)); // R1

  AST_DROP_FF: assert property (@(posedge clk) disable iff (rst)
    (ntf_valid && ntf_prio == 8'hFF && !ack_strobe) |=> (pend_buf == $past(pend_buf))); // R3

  AST_OUT_RANGE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (ntf_valid && ntf_prio >= 8'd8 && !ack_strobe) |=> (pend_buf == $past(pend_buf))); // R2

  AST_EMPTY_PRIO: assert property (@(posedge clk) disable iff (rst)
    (pend_buf == 8'h00) |-> (pend_prio == 8'hFF)); // R4

  AST_LEAD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (pend_buf != 8'h00) |-> (pend_prio < 8'd8 && pend_buf[3'd7 - pend_prio[2:0]] &&
                             ((pend_buf & ~(8'hFF >> pend_prio[2:0])) == 8'h00))); // R4

  AST_CUR_CLAMP: assert property (@(posedge clk) disable iff (rst)
    (cur_wr_en && !ack_strobe && cur_wr_data > 8'd7) |=> (cur_prio == 8'hFF)); // R5

  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (rst)
    (pend_prio < cur_prio && !ack_strobe) |=> irq); // R6

  AST_STATUS_MIRROR: assert property (@(posedge clk) disable iff (rst)
    status == {irq, 7'b0}); // R6

  AST_ACK_EFFECT: assert property (@(posedge clk) disable iff (rst)
    ack_strobe |=> (!irq && cur_prio == $past(pend_prio))); // R7

  AST_RESET_STATE: assert property (@(posedge clk)
    $past(rst) |-> (pend_buf == 8'h00 && cur_prio == 8'h00 && !irq)); // R10
endmodule

bind ipp_presenter ipp_presenter_chk u_chk (
  .clk(clk), .rst(rst), .ntf_valid(ntf_valid), .ntf_prio(ntf_prio),
  .cur_wr_en(cur_wr_en), .cur_wr_data(cur_wr_data), .ack_strobe(ack_strobe),
  .pend_buf(pend_buf), .pend_prio(pend_prio), .cur_prio(cur_prio),
  .status(status), .irq(irq)
);

// File: tb/tb_ipp_presenter.sv
module tb_ipp_presenter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ntf_valid = 1'b0;
  logic [7:0] ntf_prio = 8'h00;
  logic       cur_wr_en = 1'b0;
  logic [7:0] cur_wr_data = 8'h00;
  logic       ack_strobe = 1'b0;
  logic [7:0] pend_buf, pend_prio, cur_prio, status;
  logic       irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  ipp_presenter dut (
    .clk(clk), .rst(rst), .ntf_valid(ntf_valid), .ntf_prio(ntf_prio),
    .cur_wr_en(cur_wr_en), .cur_wr_data(cur_wr_data), .ack_strobe(ack_strobe),
    .pend_buf(pend_buf), .pend_prio(pend_prio), .cur_prio(cur_prio),
    .status(status), .irq(irq)
  );

  typedef struct packed {
    logic       nv; logic [7:0] np;
    logic       wv; logic [7:0] wd;
    logic       ak;
    logic [7:0] eb; logic [7:0] ep; logic [7:0] ec; logic ei;
  } vec_t;

  localparam int NV = 14;
  // Each row: one event cycle, then one idle cycle, then all outputs compared.
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'h03, 1'b0, 8'h00, 1'b0, 8'h10, 8'h03, 8'h00, 1'b0}, // R1 level 3 -> bit 4
    '{1'b0, 8'h00, 1'b1, 8'h05, 1'b0, 8'h10, 8'h03, 8'h05, 1'b1}, // R6 3 < 5 raises
    '{1'b1, 8'h06, 1'b0, 8'h00, 1'b0, 8'h12, 8'h03, 8'h05, 1'b1}, // R1 OR accumulate
    '{1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 8'h02, 8'h06, 8'h03, 1'b0}, // R7 ack level 3
    '{1'b1, 8'hFF, 1'b0, 8'h00, 1'b0, 8'h02, 8'h06, 8'h03, 1'b0}, // R3 0xFF dropped
    '{1'b1, 8'h09, 1'b0, 8'h00, 1'b0, 8'h02, 8'h06, 8'h03, 1'b0}, // R2 out of range
    '{1'b0, 8'h00, 1'b1, 8'h20, 1'b0, 8'h02, 8'h06, 8'hFF, 1'b1}, // R5 clamp to 0xFF
    '{1'b1, 8'h00, 1'b0, 8'h00, 1'b0, 8'h82, 8'h00, 8'hFF, 1'b1}, // R4 level 0 on top
    '{1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 8'h02, 8'h06, 8'h00, 1'b0}, // R7 ack level 0
    '{1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 8'h00, 8'hFF, 8'h06, 1'b0}, // R4 empty reads 0xFF
    '{1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 8'h00, 8'hFF, 8'hFF, 1'b0}, // R7 ack with none pending
    '{1'b1, 8'h07, 1'b0, 8'h00, 1'b0, 8'h01, 8'h07, 8'hFF, 1'b1}, // R6 7 < 0xFF
    '{1'b0, 8'h00, 1'b1, 8'h07, 1'b0, 8'h01, 8'h07, 8'h07, 1'b1}, // R6 flag sticky
    '{1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 8'h00, 8'hFF, 8'h07, 1'b0}  // R7 ack level 7
  };
  string VTAG [NV] = '{"R1","R6","R1","R7","R3","R2","R5","R4","R7","R4","R7","R6","R6","R7"};

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic nv, input logic [7:0] np, input logic wv,
                       input logic [7:0] wd, input logic ak);
    @(negedge clk);
    ntf_valid = nv; ntf_prio = np; cur_wr_en = wv; cur_wr_data = wd; ack_strobe = ak;
    @(negedge clk);
    ntf_valid = 1'b0; cur_wr_en = 1'b0; ack_strobe = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 pend_buf after reset", pend_buf, 8'h00);
    check("R10 pend_prio after reset", pend_prio, 8'hFF);
    check("R10 cur_prio after reset", cur_prio, 8'h00);
    check("R10 status after reset", status, 8'h00);
    check("R10 irq after reset", {7'b0, irq}, 8'h00);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].nv, VECS[i].np, VECS[i].wv, VECS[i].wd, VECS[i].ak);
      idle();
      check($sformatf("%s vec %0d pend_buf", VTAG[i], i), pend_buf, VECS[i].eb);
      check($sformatf("%s vec %0d pend_prio", VTAG[i], i), pend_prio, VECS[i].ep);
      check($sformatf("%s vec %0d cur_prio", VTAG[i], i), cur_prio, VECS[i].ec);
      check($sformatf("%s vec %0d irq", VTAG[i], i), {7'b0, irq}, {7'b0, VECS[i].ei});
      check($sformatf("%s vec %0d status", VTAG[i], i), status, {VECS[i].ei, 7'b0});
    end

    // R9: mask visible right after the edge, irq one edge later
    drive(1'b1, 8'h02, 1'b0, 8'h00, 1'b0);
    check("R9 pend_buf after first edge", pend_buf, 8'h20);
    check("R9 pend_prio after first edge", pend_prio, 8'h02);
    check("R9 irq still low after first edge", {7'b0, irq}, 8'h00);
    idle();
    check("R9 irq high after second edge", {7'b0, irq}, 8'h01);
    check("R6 status flag bit 7", status, 8'h80);

    // R8: ack + notify + threshold write in one cycle
    drive(1'b1, 8'h04, 1'b1, 8'h07, 1'b1);
    idle();
    check("R8 pend_buf after collision", pend_buf, 8'h08);
    check("R8 pend_prio after collision", pend_prio, 8'h04);
    check("R8 ack wins cur_prio", cur_prio, 8'h02);
    check("R8 irq after collision", {7'b0, irq}, 8'h00);

    // R8: notify and ack of the same level in one cycle keeps the bit
    drive(1'b1, 8'h04, 1'b0, 8'h00, 1'b1);
    idle();
    check("R8 same-level notify survives ack", pend_buf, 8'h08);
    check("R8 cur_prio after same-level ack", cur_prio, 8'h04);

    // R10: reset in mid run
    drive(1'b1, 8'h00, 1'b0, 8'h00, 1'b0);
    idle();
    check("R10 irq before mid-run reset", {7'b0, irq}, 8'h01);
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check("R10 pend_buf mid-run reset", pend_buf, 8'h00);
    check("R10 pend_prio mid-run reset", pend_prio, 8'hFF);
    check("R10 cur_prio mid-run reset", cur_prio, 8'h00);
    check("R10 irq mid-run reset", {7'b0, irq}, 8'h00);
    rst = 1'b0;
    idle();

    done = 1'b1;
    summary();
    $finish;
  end
endmodule